// File: doc/BRIEF.md
# Synchronous Two-Gate PWM Generator with Dead Time

This block turns a duty command into a pair of complementary gate enables for a synchronous step-down power stage. One enable drives the high-side switch and the other drives the low-side switch. The switching period is counted in system clock cycles. An external synchronisation input can end a period early, which raises the switching rate. The duty command is a count of clock cycles per period. It is taken once at the start of each period and limited to 90% of the nominal period.

The two gate enables are never on together. A fixed gap of dead-time cycles separates one gate turning off from the other turning on.

Two window-comparator flags can override the loop:
- A flag that says feedback is above the window forces zero duty.
- A flag that says feedback is below the window forces maximum duty.

Neither flag acts until it has been seen at a number of consecutive period starts. The below-window override is ignored while soft start runs. After enable, the low-side gate stays off until the high-side gate has switched on once.

Top module: `sync_pwm_deadtime`

## Requirements
- R1: With a duty of d cycles (0 < d ≤ 90 and d greater than the dead time D = 4), each 100-cycle period has d−D high-side cycles and 100−d−D low-side cycles. With a duty of 0, the high side stays off and the low side stays on for the whole period.
- R2: hs_gate and ls_gate are never 1 in the same cycle.
- R3: While en is 0, both gates are 0 from the cycle after en falls. Both gates are 0 during and straight after reset.
- R4: A gate turns on only after both gates have been off for at least D = 4 consecutive cycles, counted from the other gate turning off.
- R5: After reset, and after every re-enable, ls_gate stays 0 until hs_gate has been 1 at least once. This holds even with a zero duty command.
- R6: A duty command above 90 cycles is treated as 90 cycles. A high-side pulse never lasts more than 90 cycles.
- R7: The duty command is sampled only in the first cycle of a period. A change in the middle of a period first affects the next period.
- R8: fb_high held for at least three periods forces zero duty: no high-side pulses, and the low side stays on.
- R9: fb_low held for at least three periods forces the 90-cycle duty, but only while soft_start is 0. While soft_start is 1, the command duty is used.
- R10: When fb_high and fb_low are both active, zero duty wins.
- R11: Rising edges on sync_in spaced 80 cycles apart, which is at least 60 cycles, make the period 80 cycles. The gate times then follow R1 with 80 in place of 100.
- R12: An override flag that stays high for only one period, so that it covers a single period start, has no effect on the gates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; 0 forces both gates off and restarts the period |
| duty_cmd | input | 7 | High-side on-time per period, in clock cycles |
| soft_start | input | 1 | Soft start running; suppresses the below-window override |
| fb_low | input | 1 | Feedback below the regulation window |
| fb_high | input | 1 | Feedback above the regulation window |
| sync_in | input | 1 | External synchronisation; a rising edge may end the period early |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The dead-time and pulse-length properties assume that the output gates start from the off state after reset or disable. They also assume the dead-time parameter is at least one cycle, and that any sync edge arrives far enough from the previous period start to respect the minimum-period guard.

The stimulus drives every input at a falling edge and holds each setting for many periods before measuring. It uses only duty values of 0 or above the dead time, and spaces sync edges 80 cycles apart. Every window it measures therefore holds whole, repeated periods.

// File: rtl/sync_pwm_pkg.sv
package sync_pwm_pkg;
  typedef struct packed {
    logic force_zero;
    logic force_max;
  } ovr_t;

  localparam int OVR_ZERO = 0;
  localparam int OVR_MAX  = 1;
endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int PERIOD_CYC = 100,
  parameter int SYNC_MIN   = 60,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             start
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic s_meta, s_sync, s_prev;
  logic sync_edge, sync_take, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= sync_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  always_comb begin
    sync_edge = s_sync & ~s_prev;
    sync_take = sync_edge && (cnt_q >= CNT_W'(SYNC_MIN - 1));
    wrap      = (cnt_q == CNT_W'(PERIOD_CYC - 1));
    if (!en)                  cnt_d = '0;
    else if (wrap || sync_take) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign start = en && (cnt_q == '0);
endmodule

// File: rtl/pwm_persist_filter.sv
module pwm_persist_filter #(
  parameter int PERSIST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic flag,
  output logic ok
);
  localparam int PW = $clog2(PERSIST + 1);
  logic [PW-1:0] seen_q, seen_d;
  logic          bump;

  always_comb begin
    bump   = start && (seen_q < PW'(PERSIST));
    seen_d = seen_q;
    if (!en || !flag) seen_d = '0;
    else if (bump)    seen_d = seen_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  assign ok = (seen_q == PW'(PERSIST));
endmodule

// File: rtl/pwm_duty_select.sv
module pwm_duty_select
  import sync_pwm_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int MAX_ON = 90
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             soft_start,
  input  ovr_t             ovr,
  output logic             hs_req
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_ON);
  logic [CNT_W-1:0] lat_q, lat_d, pick, eff;

  always_comb begin
    if (ovr.force_zero)                   pick = '0;
    else if (ovr.force_max && !soft_start) pick = CAP;
    else if (duty_cmd > CAP)              pick = CAP;
    else                                  pick = duty_cmd;
    lat_d  = start ? pick : lat_q;
    eff    = start ? pick : lat_q;
    hs_req = en && (cnt < eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq #(
  parameter int DEAD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hs_req,
  output logic hs_gate,
  output logic ls_gate
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  logic          hs_q, hs_d, ls_q, ls_d, armed_q, armed_d;
  logic [DW-1:0] dc_q, dc_d;
  logic          gap_done;

  always_comb begin
    gap_done = (dc_q == '0);
    hs_d     = en && hs_req && !ls_q && gap_done;
    ls_d     = en && !hs_req && !hs_q && gap_done && armed_q;
    armed_d  = en && (armed_q || hs_q);
    if ((hs_q && !hs_d) || (ls_q && !ls_d)) dc_d = DW'(DEAD_CYC - 1);
    else if (!gap_done)                     dc_d = dc_q - 1'b1;
    else                                    dc_d = dc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
      armed_q <= 1'b0;
      dc_q    <= '0;
    end else begin
      hs_q    <= hs_d;
      ls_q    <= ls_d;
      armed_q <= armed_d;
      dc_q    <= dc_d;
    end
  end

  assign hs_gate = hs_q;
  assign ls_gate = ls_q;
endmodule

// File: rtl/sync_pwm_deadtime.sv
module sync_pwm_deadtime
  import sync_pwm_pkg::*;
#(
  parameter int PERIOD_CYC   = 100,
  parameter int DEAD_CYC     = 4,
  parameter int MAX_PCT      = 90,
  parameter int SYNC_MIN_PCT = 60,
  parameter int PERSIST      = 2,
  parameter int CNT_W        = $clog2(PERIOD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             soft_start,
  input  logic             fb_low,
  input  logic             fb_high,
  input  logic             sync_in,
  output logic             hs_gate,
  output logic             ls_gate
);
  localparam int MAX_ON   = PERIOD_CYC * MAX_PCT / 100;
  localparam int SYNC_MIN = PERIOD_CYC * SYNC_MIN_PCT / 100;

  logic             rs_meta, rs_n;
  logic [CNT_W-1:0] cnt;
  logic             start, hs_req;
  logic [1:0]       flags, oks;
  ovr_t             ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  pwm_period_timer #(
    .PERIOD_CYC(PERIOD_CYC), .SYNC_MIN(SYNC_MIN), .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk), .rst_n(rs_n), .en(en), .sync_in(sync_in),
    .cnt(cnt), .start(start)
  );

  assign flags[OVR_ZERO] = fb_high;
  assign flags[OVR_MAX]  = fb_low;

  for (genvar i = 0; i < 2; i++) begin : g_filt
    pwm_persist_filter #(.PERSIST(PERSIST)) u_filt (
      .clk(clk), .rst_n(rs_n), .en(en), .start(start),
      .flag(flags[i]), .ok(oks[i])
    );
  end

  assign ovr.force_zero = oks[OVR_ZERO];
  assign ovr.force_max  = oks[OVR_MAX];

  pwm_duty_select #(.CNT_W(CNT_W), .MAX_ON(MAX_ON)) u_duty (
    .clk(clk), .rst_n(rs_n), .en(en), .start(start), .cnt(cnt),
    .duty_cmd(duty_cmd), .soft_start(soft_start), .ovr(ovr),
    .hs_req(hs_req)
  );

  pwm_gate_seq #(.DEAD_CYC(DEAD_CYC)) u_gate (
    .clk(clk), .rst_n(rs_n), .en(en), .hs_req(hs_req),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int DEAD_CYC = 4,
  parameter int MAX_ON   = 90
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic hs_gate,
  input logic ls_gate
);
  logic [15:0] gap_q, run_q;
  logic        last_ls_q, seen_hs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      run_q     <= '0;
      last_ls_q <= 1'b0;
      seen_hs_q <= 1'b0;
    end else begin
      gap_q     <= (!hs_gate && !ls_gate && gap_q != 16'hFFFF) ? gap_q + 1'b1 : (hs_gate || ls_gate) ? '0 : gap_q;
      run_q     <= hs_gate ? run_q + 1'b1 : '0;
      last_ls_q <= ls_gate ? 1'b1 : hs_gate ? 1'b0 : last_ls_q;
      seen_hs_q <= !en ? 1'b0 : (seen_hs_q || hs_gate);
    end
  end

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  a_r3_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_gate && !ls_gate));

  a_r4_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_gate) |-> (gap_q >= 16'(DEAD_CYC)));

  a_r4_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_gate) && last_ls_q) |-> (gap_q >= 16'(DEAD_CYC)));

  a_r5_ls_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gate |-> seen_hs_q);

  a_r6_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> (run_q < 16'(MAX_ON)));
endmodule

bind sync_pwm_deadtime pwm_checker #(.DEAD_CYC(DEAD_CYC), .MAX_ON(MAX_ON)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .hs_gate(hs_gate), .ls_gate(ls_gate)
);

// File: tb/tb_sync_pwm_deadtime.sv
module tb_sync_pwm_deadtime;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 100;
  localparam int D  = 4;
  localparam int MX = 90;
  localparam int NV = 8;
  localparam int VDUTY [NV] = '{50, 20, 95, 0, 30, 30, 60, 60};
  localparam int VLOW  [NV] = '{0, 0, 0, 0, 1, 1, 0, 1};
  localparam int VHIGH [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam int VSS   [NV] = '{0, 0, 0, 0, 0, 1, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [6:0] duty_cmd = '0;
  logic soft_start = 1'b0, fb_low = 1'b0, fb_high = 1'b0, sync_in = 1'b0;
  logic hs_gate, ls_gate;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit sync_run = 1'b0;

  sync_pwm_deadtime dut (
    .clk(clk), .rst_n(rst_n), .en(en), .duty_cmd(duty_cmd),
    .soft_start(soft_start), .fb_low(fb_low), .fb_high(fb_high),
    .sync_in(sync_in), .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : sync_gen
    forever begin
      @(negedge clk);
      if (sync_run) begin
        sync_in = 1'b1;
        repeat (4) @(negedge clk);
        sync_in = 1'b0;
        repeat (75) @(negedge clk);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(int n, output int h, output int l);
    h = 0; l = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(hs_gate);
      l += int'(ls_gate);
    end
  endtask

  function automatic int eff_duty(int d, int lo, int hi, int ss);
    if (hi != 0) return 0;
    if (lo != 0 && ss == 0) return MX;
    return (d > MX) ? MX : d;
  endfunction

  function automatic int exp_hs(int e, int per);
    return (e == 0) ? 0 : e - D;
  endfunction

  function automatic int exp_ls(int e, int per);
    return (e == 0) ? per : per - e - D;
  endfunction

  initial begin : main
    int h, l, e, run, seen;
    repeat (3) @(negedge clk);
    check("R3 reset hs", int'(hs_gate), 0);
    check("R3 reset ls", int'(ls_gate), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b1;
    duty_cmd = 7'd0;
    measure(300, h, l);
    check("R5 holdoff ls at zero duty", l, 0);

    for (int i = 0; i < NV; i++) begin
      duty_cmd = 7'(VDUTY[i]);
      fb_low = VLOW[i][0]; fb_high = VHIGH[i][0]; soft_start = VSS[i][0];
      repeat (6 * P) @(negedge clk);
      measure(4 * P, h, l);
      e = eff_duty(VDUTY[i], VLOW[i], VHIGH[i], VSS[i]);
      check($sformatf("R1/R6/R8/R9/R10 vec%0d hs", i), h, 4 * exp_hs(e, P));
      check($sformatf("R1/R6/R8/R9/R10 vec%0d ls", i), l, 4 * exp_ls(e, P));
    end
    fb_low = 1'b0; fb_high = 1'b0; soft_start = 1'b0;

    duty_cmd = 7'd50;
    repeat (6 * P) @(negedge clk);
    while (hs_gate) @(negedge clk);
    while (!hs_gate) @(negedge clk);
    run = 0;
    repeat (10) begin run += int'(hs_gate); @(negedge clk); end
    duty_cmd = 7'd20;
    while (hs_gate) begin run++; @(negedge clk); end
    check("R7 current pulse unchanged", run, 50 - D);
    while (!hs_gate) @(negedge clk);
    run = 0;
    while (hs_gate) begin run++; @(negedge clk); end
    check("R7 next pulse uses new duty", run, 20 - D);

    duty_cmd = 7'd30;
    repeat (6 * P) @(negedge clk);
    h = 0;
    repeat (150) begin @(negedge clk); h += int'(hs_gate); end
    fb_low = 1'b1;
    repeat (100) begin @(negedge clk); h += int'(hs_gate); end
    fb_low = 1'b0;
    repeat (150) begin @(negedge clk); h += int'(hs_gate); end
    check("R12 one-period flag ignored", h, 4 * (30 - D));

    duty_cmd = 7'd40;
    sync_run = 1'b1;
    repeat (8 * P) @(negedge clk);
    measure(4 * 80, h, l);
    check("R11 synced hs", h, 4 * exp_hs(40, 80));
    check("R11 synced ls", l, 4 * exp_ls(40, 80));
    sync_run = 1'b0;
    repeat (3 * P) @(negedge clk);

    while (!hs_gate) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R3 disable hs", int'(hs_gate), 0);
    check("R3 disable ls", int'(ls_gate), 0);
    repeat (20) @(negedge clk);
    duty_cmd = 7'd0;
    en = 1'b1;
    measure(300, h, l);
    check("R5 re-enable holdoff ls", l, 0);
    duty_cmd = 7'd50;
    seen = 0;
    repeat (300) begin @(negedge clk); if (ls_gate) seen = 1; end
    check("R5 ls after first hs", seen, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule